// File: doc/BRIEF.md
# Bit Manipulation and Shift Unit

This block is a registered 32-bit bit-manipulation engine for an integer datapath. A caller presents an opcode, a value `x` and an operand `y` together with a one-cycle `start` pulse. On the next clock edge the unit captures the result of that operation in its output register and raises `valid` for exactly one cycle. With `start` low the result register holds its last value.

The operation set covers logical and arithmetic shifts and rotates, a highest-set-bit encoder and a population count. It also builds fields: a one-hot decode, a low-bit mask, a reversal of the low bits with clearing above them, and zero- or sign-extension from a chosen bit. Every amount or bit index is taken from the low five bits of its operand only, so large amounts wrap and never saturate. The encoder gives 0 for a zero input, which is the same answer it gives for an input of 1.

Top module: `bitu_core`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `result` is 0 and `valid` is 0.
- R2: A cycle with `start` high makes `valid` high on the next cycle. A cycle with `start` low makes `valid` low on the next cycle and leaves `result` unchanged, whatever `op`, `x` and `y` do.
- R3: Opcode 0 shifts `x` left and opcode 1 shifts `x` right, both filling with zeros, by `y[4:0]`. The upper bits of `y` are ignored, so an amount of 32 shifts by 0 and 33 shifts by 1.
- R4: Opcode 2 shifts `x` right by `y[4:0]` and fills the vacated upper bits with copies of `x[31]`.
- R5: Opcode 3 rotates `x` left and opcode 4 rotates `x` right by `y[4:0]`.
- R6: Opcode 5 returns the index 0..31 of the highest set bit of `x`, and 0 when `x` is 0.
- R7: Opcode 6 returns a word with only bit `x[4:0]` set.
- R8: Opcode 7 returns a mask whose bits 0 through `x[4:0]` are set and all others clear (1 to 32 set bits).
- R9: Opcode 8, with n = `y[4:0]`, sets bit i of the result to `x[n-i]` for i from 0 to n and clears every bit above n.
- R10: Opcode 9, with n = `y[4:0]`, keeps bits n..0 of `x` and clears the rest; opcode 10 keeps bits n..0 and copies `x[n]` into every higher bit.
- R11: Opcode 11 returns the number of set bits in `x` (0 to 32).
- R12: Opcodes 12 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches the operation on `op`, `x`, `y` this cycle |
| op | input | 4 | Operation code, see requirements |
| x | input | 32 | Value operand (index source for decode and mask) |
| y | input | 32 | Amount or bit-index operand, low 5 bits used |
| result | output | 32 | Registered result of the last launched operation |
| valid | output | 1 | High for one cycle when `result` has just been updated |

## Verification
The bench targets amounts of 32 and 33, where a saturating shifter would return 0 instead of the wrapped result, and rotates by 0, where a rotate built from two shifts can OR in the whole word. It drives the encoder with 0, 1 and the top bit, where an off-by-one encoder returns 32 or a count instead of an index, and the mask and decode with indices 0 and 31, where a mask computed in 32 bits without care loses the top bit or wraps to 0. Reverse and extension run at indices 0, 7 and 31 to catch mirrors that keep bits above the index or sign fills taken from the wrong bit. Every operation is also followed by an idle cycle with changed inputs to expose a result register that loads without `start`.

// File: rtl/bitu_pkg.sv
package bitu_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_SHL = 4'd0,
        OP_SHR = 4'd1,
        OP_SAR = 4'd2,
        OP_ROL = 4'd3,
        OP_ROR = 4'd4,
        OP_ENC = 4'd5,
        OP_DEC = 4'd6,
        OP_MSK = 4'd7,
        OP_REV = 4'd8,
        OP_ZXT = 4'd9,
        OP_SXT = 4'd10,
        OP_CNT = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        GRP_NONE  = 2'd0,
        GRP_SHIFT = 2'd1,
        GRP_FIELD = 2'd2,
        GRP_SCAN  = 2'd3
    } grp_e;

    // Which sub-unit serves an opcode.
    function automatic grp_e op_group(input logic [OP_W-1:0] op);
        case (op)
            OP_SHL, OP_SHR, OP_SAR, OP_ROL, OP_ROR: return GRP_SHIFT;
            OP_DEC, OP_MSK, OP_REV, OP_ZXT, OP_SXT: return GRP_FIELD;
            OP_ENC, OP_CNT:                         return GRP_SCAN;
            default:                                return GRP_NONE;
        endcase
    endfunction

    // Decode and mask take their index from x, the rest from y.
    function automatic logic idx_from_x(input logic [OP_W-1:0] op);
        return (op == OP_DEC) || (op == OP_MSK);
    endfunction

endpackage

// File: rtl/bitu_shift.sv
module bitu_shift
    import bitu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [OP_W-1:0]       op,
    input  logic [W-1:0]          val,
    input  logic [$clog2(W)-1:0]  amt,
    output logic [W-1:0]          res
);
    localparam int unsigned DW = 2 * W;

    logic [DW-1:0] dbl_l;
    logic [DW-1:0] dbl_r;
    logic [W-1:0]  sar_v;

    always_comb begin
        dbl_l = {val, val} << amt;
        dbl_r = {val, val} >> amt;
        sar_v = W'($signed(val) >>> amt);
    end

    always_comb begin
        case (op)
            OP_SHL:  res = val << amt;
            OP_SHR:  res = val >> amt;
            OP_SAR:  res = sar_v;
            OP_ROL:  res = dbl_l[DW-1:W];
            OP_ROR:  res = dbl_r[W-1:0];
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/bitu_field.sv
module bitu_field
    import bitu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [OP_W-1:0]       op,
    input  logic [W-1:0]          val,
    input  logic [$clog2(W)-1:0]  idx,
    output logic [W-1:0]          res
);
    localparam int unsigned AW = $clog2(W);
    localparam logic [AW-1:0] TOP = AW'(W - 1);

    logic [W-1:0] mirror;
    logic [W-1:0] low_mask;
    logic [W-1:0] one_hot;
    logic [W-1:0] kept;
    logic [W-1:0] reversed;
    logic         fill_bit;

    for (genvar g = 0; g < W; g++) begin : g_mirror
        assign mirror[g] = val[W-1-g];
    end

    always_comb begin
        low_mask = {W{1'b1}} >> (TOP - idx);
        one_hot  = {{(W-1){1'b0}}, 1'b1} << idx;
        kept     = val & low_mask;
        reversed = mirror >> (TOP - idx);
        fill_bit = val[idx];
    end

    always_comb begin
        case (op)
            OP_DEC:  res = one_hot;
            OP_MSK:  res = low_mask;
            OP_REV:  res = reversed;
            OP_ZXT:  res = kept;
            OP_SXT:  res = kept | (fill_bit ? ~low_mask : '0);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/bitu_scan.sv
module bitu_scan
    import bitu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    val,
    output logic [W-1:0]    res
);
    localparam int unsigned AW = $clog2(W);
    localparam int unsigned CW = $clog2(W + 1);

    logic [AW-1:0] top_idx;
    logic [CW-1:0] ones;

    always_comb begin
        top_idx = '0;
        for (int i = 0; i < W; i++) begin
            if (val[i]) top_idx = AW'(i);
        end
    end

    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + CW'(val[i]);
        end
    end

    always_comb begin
        case (op)
            OP_ENC:  res = W'(top_idx);
            OP_CNT:  res = W'(ones);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/bitu_core.sv
module bitu_core
    import bitu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    x,
    input  logic [W-1:0]    y,
    output logic [W-1:0]    result,
    output logic            valid
);
    localparam int unsigned AW = $clog2(W);

    logic [AW-1:0] idx_sel;
    logic [W-1:0]  shift_res;
    logic [W-1:0]  field_res;
    logic [W-1:0]  scan_res;
    logic [W-1:0]  next_res;
    logic          unused_y_hi;

    assign unused_y_hi = ^y[W-1:AW];
    assign idx_sel     = idx_from_x(op) ? x[AW-1:0] : y[AW-1:0];

    bitu_shift #(.W(W)) u_shift (
        .op  (op),
        .val (x),
        .amt (y[AW-1:0]),
        .res (shift_res)
    );

    bitu_field #(.W(W)) u_field (
        .op  (op),
        .val (x),
        .idx (idx_sel),
        .res (field_res)
    );

    bitu_scan #(.W(W)) u_scan (
        .op  (op),
        .val (x),
        .res (scan_res)
    );

    always_comb begin
        case (op_group(op))
            GRP_SHIFT: next_res = shift_res;
            GRP_FIELD: next_res = field_res;
            GRP_SCAN:  next_res = scan_res;
            default:   next_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= start;
            if (start) result <= next_res;
        end
    end
endmodule

// File: rtl/bitu_core_chk.sv
module bitu_core_chk
    import bitu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [OP_W-1:0] op,
    input logic [W-1:0]    x,
    input logic [W-1:0]    y,
    input logic [W-1:0]    result,
    input logic            valid
);
    logic unused_y;
    assign unused_y = ^y;

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (result == '0 && !valid));

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> valid);

    p_idle_holds_r2: assert property (@(posedge clk) disable iff (rst)
        !start |=> (!valid && $stable(result)));

    p_sar_sign_r4: assert property (@(posedge clk) disable iff (rst)
        (start && op == OP_SAR && x[W-1]) |=> result[W-1]);

    p_rot_keeps_ones_r5: assert property (@(posedge clk) disable iff (rst)
        (start && (op == OP_ROL || op == OP_ROR)) |=>
            ($countones(result) == $countones($past(x))));

    p_enc_range_r6: assert property (@(posedge clk) disable iff (rst)
        (start && op == OP_ENC) |=> (result < W));

    p_dec_single_r7: assert property (@(posedge clk) disable iff (rst)
        (start && op == OP_DEC) |=> ($countones(result) == 1));

    p_mask_shape_r8: assert property (@(posedge clk) disable iff (rst)
        (start && op == OP_MSK) |=> (result[0] && ((result + 1'b1) & result) == '0));

    p_cnt_range_r11: assert property (@(posedge clk) disable iff (rst)
        (start && op == OP_CNT) |=> (result <= W));

    p_undef_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (start && op >= 4'd12) |=> (result == '0));
endmodule

bind bitu_core bitu_core_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op     (op),
    .x      (x),
    .y      (y),
    .result (result),
    .valid  (valid)
);

// File: tb/bitu_core_test.sv
module bitu_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 600;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [3:0]  op;
    logic [31:0] x;
    logic [31:0] y;
    logic [31:0] result;
    logic        valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitu_core uut (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .op     (op),
        .x      (x),
        .y      (y),
        .result (result),
        .valid  (valid)
    );

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0, 4'd1: return "R3";
            4'd2:       return "R4";
            4'd3, 4'd4: return "R5";
            4'd5:       return "R6";
            4'd6:       return "R7";
            4'd7:       return "R8";
            4'd8:       return "R9";
            4'd9, 4'd10: return "R10";
            4'd11:      return "R11";
            default:    return "R12";
        endcase
    endfunction

    function automatic logic [31:0] model(input logic [3:0] o,
                                          input logic [31:0] a,
                                          input logic [31:0] b);
        logic [31:0] r = '0;
        int n = int'(b[4:0]);
        int m = int'(a[4:0]);
        case (o)
            4'd0: for (int i = 0; i < 32; i++) if (i >= n) r[i] = a[i-n];
            4'd1: for (int i = 0; i < 32; i++) if (i + n < 32) r[i] = a[i+n];
            4'd2: for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? a[i+n] : a[31];
            4'd3: for (int i = 0; i < 32; i++) r[(i+n)%32] = a[i];
            4'd4: for (int i = 0; i < 32; i++) r[i] = a[(i+n)%32];
            4'd5: for (int i = 0; i < 32; i++) if (a[i]) r = 32'(i);
            4'd6: r[m] = 1'b1;
            4'd7: for (int i = 0; i <= m; i++) r[i] = 1'b1;
            4'd8: for (int i = 0; i <= n; i++) r[i] = a[n-i];
            4'd9: for (int i = 0; i <= n; i++) r[i] = a[i];
            4'd10: for (int i = 0; i < 32; i++) r[i] = (i <= n) ? a[i] : a[n];
            4'd11: for (int i = 0; i < 32; i++) r = r + 32'(a[i]);
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %08h expected %08h", req, what, got, exp);
        end
    endtask

    // Launch one operation, check its result, then check an idle cycle.
    task automatic run(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] exp;
        exp = model(o, a, b);
        @(negedge clk);
        start = 1'b1; op = o; x = a; y = b;
        @(negedge clk);
        start = 1'b0;
        check(req_of(o), $sformatf("op %0d result", o), result, exp);
        check("R2", "valid after start", {31'b0, valid}, 32'd1);
        op = 4'($urandom); x = $urandom; y = $urandom;
        @(negedge clk);
        check("R2", "valid idle", {31'b0, valid}, 32'd0);
        check("R2", "result held idle", result, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; start = 1'b0; op = '0; x = '0; y = '0;
        repeat (3) @(negedge clk);
        check("R1", "result in reset", result, 32'd0);
        check("R1", "valid in reset", {31'b0, valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "result after reset", result, 32'd0);
        check("R1", "valid after reset", {31'b0, valid}, 32'd0);

        // R3: amounts wrap at 32
        run(4'd0, 32'h0000_00F1, 32'd32);
        run(4'd0, 32'h0000_00F1, 32'd33);
        run(4'd1, 32'h8000_0000, 32'd31);
        run(4'd1, 32'hDEAD_BEEF, 32'hFFFF_FFE4);
        // R4: sign fill
        run(4'd2, 32'h8000_0000, 32'd31);
        run(4'd2, 32'h4000_0000, 32'd30);
        // R5: rotates, including amount 0 and 32
        run(4'd3, 32'h8000_0001, 32'd0);
        run(4'd3, 32'h8000_0001, 32'd1);
        run(4'd4, 32'h8000_0001, 32'd32);
        run(4'd4, 32'h0000_0003, 32'd1);
        // R6: encode corners
        run(4'd5, 32'h0000_0000, 32'd0);
        run(4'd5, 32'h0000_0001, 32'd0);
        run(4'd5, 32'h8000_0000, 32'd0);
        // R7 and R8: index 0, 31 and wrapped 35
        run(4'd6, 32'd35, 32'd0);
        run(4'd6, 32'd31, 32'd0);
        run(4'd7, 32'd0, 32'd0);
        run(4'd7, 32'd31, 32'd0);
        run(4'd7, 32'd39, 32'd0);
        // R9: reverse at 0, 7, 31
        run(4'd8, 32'hFFFF_FF01, 32'd7);
        run(4'd8, 32'hFFFF_FFFE, 32'd0);
        run(4'd8, 32'h0000_0001, 32'd31);
        // R10: zero and sign extension
        run(4'd9, 32'hFFFF_FF80, 32'd7);
        run(4'd10, 32'h0000_0080, 32'd7);
        run(4'd10, 32'hFFFF_FF7F, 32'd7);
        run(4'd10, 32'h8000_0000, 32'd31);
        // R11: counts
        run(4'd11, 32'hFFFF_FFFF, 32'd0);
        run(4'd11, 32'h0000_0000, 32'd0);
        // R12: undefined opcodes
        run(4'd12, 32'hFFFF_FFFF, 32'd5);
        run(4'd15, 32'h1234_5678, 32'd1);

        for (int k = 0; k < N_RANDOM; k++) begin
            run(4'($urandom), $urandom, $urandom);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule